// File: doc/BRIEF.md
# Dual Prescaled Interval Timer

This block holds two independent periodic timers for an audio subsystem. The first sets the sample-rate interrupt and the second sets the tempo interrupt. Each timer has a 16-bit prescaler and a 16-bit divider. A timer's period in clocks is the product of the two values, each plus one. The count is a cascade: a prescaler stage counts down every clock, and a divider stage steps once each time the prescaler stage wraps. The timer expires when both stages wrap together. After each expiry it reloads by itself.

A register bus with byte or word access writes and reads back all four reload values. The same bus reaches an interrupt control register, which holds per-source enable bits and write-one-to-clear bits for the two timer sources. Any write to a timer's prescaler or divider restarts that timer at once with the new period. A zero in either value stops the timer. On expiry the block drives a one-cycle tick. When the matching enable bit is set, the expiry also sets a pending flag, and that flag stays high until software clears it.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset all four reload registers read 0xFFFF, both timers are idle and give no tick, all enable bits are 0 and no interrupt is pending.
- R2: A word access (`bus_word`=1) at byte offset 0 reaches the timer 1 prescaler, 2 the timer 1 divider, 4 the timer 2 prescaler and 6 the timer 2 divider. A written word reads back unchanged.
- R3: A byte access (`bus_word`=0) carries its data in bits [7:0]. An even address selects the high byte of the register and an odd address the low byte, and the other byte is kept. A byte read returns the addressed byte in `bus_rdata[7:0]`, with zeros above it.
- R4: With prescaler P and divider D both nonzero, the timer's tick is high for exactly one cycle. The first tick comes N=(1+P)×(1+D) cycles after the clock edge that took the write, and further ticks follow every N cycles.
- R5: When either the prescaler or the divider of a timer is zero, that timer gives no tick and sets no pending flag.
- R6: Any byte or word write to a timer's prescaler or divider restarts that timer's count from the edge that takes the write.
- R7: The two timers are independent. A write to one timer's registers does not shift the other timer's ticks.
- R8: The control register is at byte offset 8. Bits [4:0] are read/write enable bits: bit 1 enables timer 1 and bit 2 enables timer 2. A tick sets its pending flag one cycle later, and only if its enable bit is 1.
- R9: Writing 1 to bit 9 (timer 1) or bit 10 (timer 2) of the control register clears that pending flag. Writing 0 there has no effect. A byte write at offset 8 reaches these bits through data bits [2:1]. A clear that falls in the same cycle as a set wins.
- R10: The divider stage steps only on a prescaler wrap, so that P=1, D=2 and P=2, D=1 both give a period of 6.
- R11: Read data is registered. It appears in the cycle after the read strobe and holds until the next read, even when the register is written in between.
- R12: A read of the control register returns the enable bits in [4:0] and the timer 1 and timer 2 pending flags in bits 9 and 10. The pending flags also drive `irq_pending[0]` and `irq_pending[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data (bytes in [7:0]) |
| bus_rdata | output | 16 | Registered read data |
| tick_pulse | output | 2 | One-cycle expiry tick per timer |
| irq_pending | output | 2 | Pending interrupt flag per timer |

## Verification
A timer expiry and a software clear of that timer's pending flag can reach the pending flag on the same clock edge. The bench arranges this by starting a period-8 timer and counting cycles from the write edge. It then times a control write carrying the clear bit so that the write's edge is the one that would set the flag from the tick. The flag is judged low right after that edge, and it is seen to set again on the next expiry, which shows that the clear won only the cycle of the conflict.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int NUM_TMR   = 2;
  localparam int NUM_SRC   = 5;
  localparam int CTRL_WORD = 4;  // byte offset 8
  localparam int TMR_EN_LO = 1;  // enable/clear bit of timer 0

  typedef struct packed {
    logic hi_we;
    logic lo_we;
  } half_we_t;

  typedef struct packed {
    half_we_t pre;
    half_we_t div;
  } tmr_we_t;
endpackage

// File: rtl/dit_timer.sv
module dit_timer
  import dit_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  tmr_we_t        we,
  input  logic [W/2-1:0] hi_byte,
  input  logic [W/2-1:0] lo_byte,
  output logic [W-1:0]   pre_q,
  output logic [W-1:0]   div_q,
  output logic           expire_q
);
  localparam int H = W / 2;

  logic [W-1:0] pre_n, div_n, pcnt, dcnt;
  logic         run, any_we;

  always_comb begin
    pre_n  = {we.pre.hi_we ? hi_byte : pre_q[W-1:H], we.pre.lo_we ? lo_byte : pre_q[H-1:0]};
    div_n  = {we.div.hi_we ? hi_byte : div_q[W-1:H], we.div.lo_we ? lo_byte : div_q[H-1:0]};
    any_we = we.pre.hi_we | we.pre.lo_we | we.div.hi_we | we.div.lo_we;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q    <= '1;
      div_q    <= '1;
      pcnt     <= '0;
      dcnt     <= '0;
      run      <= 1'b0;
      expire_q <= 1'b0;
    end else begin
      pre_q    <= pre_n;
      div_q    <= div_n;
      expire_q <= 1'b0;
      if (any_we) begin
        pcnt <= pre_n;
        dcnt <= div_n;
        run  <= (|pre_n) && (|div_n);
      end else if (run) begin
        if (pcnt == '0) begin
          pcnt <= pre_q;
          if (dcnt == '0) begin
            dcnt     <= div_q;
            expire_q <= 1'b1;
          end else begin
            dcnt <= dcnt - 1'b1;
          end
        end else begin
          pcnt <= pcnt - 1'b1;
        end
      end
    end
  end

  // R1: leaving reset, reload values are all ones and the counter is idle
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pre_q == '1 && div_q == '1 && !run));

  // R4: a tick never lasts two cycles
  assert_single_tick_R4: assert property (@(posedge clk) disable iff (rst)
    expire_q |=> !expire_q);

  // R5: a zero reload value keeps the tick low
  assert_zero_stops_R5: assert property (@(posedge clk) disable iff (rst)
    ((pre_q == '0 || div_q == '0) && !any_we) |=> !expire_q);

  // R6: a write restarts both stages from the new reload values
  assert_reload_on_write_R6: assert property (@(posedge clk) disable iff (rst)
    any_we |=> (pcnt == pre_q && dcnt == div_q));

  // R10: the divider stage holds while the prescaler stage has not wrapped
  assert_cascade_step_R10: assert property (@(posedge clk) disable iff (rst)
    (run && !any_we && pcnt != '0) |=> $stable(dcnt));
endmodule

// File: rtl/dit_irq_ctrl.sv
module dit_irq_ctrl
  import dit_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int NT   = NUM_TMR
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_data,
  input  logic [NT-1:0]   clr_mask,
  input  logic [NT-1:0]   tick,
  output logic [NSRC-1:0] en_q,
  output logic [NT-1:0]   pend_q
);
  logic [NT-1:0] tmr_en;
  assign tmr_en = en_q[TMR_EN_LO +: NT];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_we) en_q <= en_data;
      pend_q <= (pend_q | (tick & tmr_en)) & ~clr_mask;
    end
  end

  // R9: a clear leaves the flag low in the next cycle, even with a tick present
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_mask != '0) |=> ((pend_q & $past(clr_mask)) == '0));

  // R8: a flag rises only when its enable bit was set
  assert_set_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    (pend_q == '0 && tmr_en == '0) |=> (pend_q == '0));
endmodule

// File: rtl/dit_regbus.sv
module dit_regbus
  import dit_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int W      = 16,
  parameter int NSRC   = NUM_SRC,
  parameter int NT     = NUM_TMR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              word,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output tmr_we_t [NT-1:0]  tmr_we,
  output logic [W/2-1:0]    hi_byte,
  output logic [W/2-1:0]    lo_byte,
  output logic              en_we,
  output logic [NSRC-1:0]   en_data,
  output logic [NT-1:0]     clr_mask,
  input  logic [NT-1:0][W-1:0] pre_in,
  input  logic [NT-1:0][W-1:0] div_in,
  input  logic [NSRC-1:0]   en_in,
  input  logic [NT-1:0]     pend_in
);
  localparam int H = W / 2;

  logic tmr_region, ctrl_region, hi_sel, lo_sel, ctrl_hi, ctrl_lo;
  logic [W-1:0] rsel, rval;

  always_comb begin
    tmr_region  = (addr[ADDR_W-1:3] == '0);
    ctrl_region = (addr[ADDR_W-1:1] == (ADDR_W-1)'(CTRL_WORD));
    hi_sel      = wr && ((word && !addr[0]) || (!word && !addr[0]));
    lo_sel      = wr && ((word && !addr[0]) || (!word && addr[0]));
    hi_byte     = word ? wdata[W-1:H] : wdata[H-1:0];
    lo_byte     = wdata[H-1:0];
    ctrl_hi     = ctrl_region && hi_sel;
    ctrl_lo     = ctrl_region && lo_sel;
    en_we       = ctrl_lo;
    en_data     = lo_byte[NSRC-1:0];
    clr_mask    = ctrl_hi ? hi_byte[TMR_EN_LO +: NT] : '0;
  end

  for (genvar t = 0; t < NT; t++) begin : g_we
    logic hit_t;
    assign hit_t              = tmr_region && (addr[2] == t[0]);
    assign tmr_we[t].pre.hi_we = hit_t && !addr[1] && hi_sel;
    assign tmr_we[t].pre.lo_we = hit_t && !addr[1] && lo_sel;
    assign tmr_we[t].div.hi_we = hit_t &&  addr[1] && hi_sel;
    assign tmr_we[t].div.lo_we = hit_t &&  addr[1] && lo_sel;
  end

  always_comb begin
    rsel = '0;
    if (tmr_region) begin
      rsel = addr[1] ? div_in[addr[2]] : pre_in[addr[2]];
    end else if (ctrl_region) begin
      rsel[NSRC-1:0]               = en_in;
      rsel[H + TMR_EN_LO +: NT]    = pend_in;
    end
    if (word) rval = rsel;
    else      rval = {{H{1'b0}}, addr[0] ? rsel[H-1:0] : rsel[W-1:H]};
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rval;
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_word,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_TMR-1:0] tick_pulse,
  output logic [NUM_TMR-1:0] irq_pending
);
  tmr_we_t [NUM_TMR-1:0]            tmr_we;
  logic [CNT_W/2-1:0]               hi_byte, lo_byte;
  logic                             en_we;
  logic [NUM_SRC-1:0]               en_data, en_q;
  logic [NUM_TMR-1:0]               clr_mask;
  logic [NUM_TMR-1:0][CNT_W-1:0]    pre_q, div_q;

  dit_regbus #(.ADDR_W(ADDR_W), .W(CNT_W), .NSRC(NUM_SRC), .NT(NUM_TMR)) u_bus (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .word(bus_word),
    .wdata(bus_wdata), .rdata(bus_rdata), .tmr_we(tmr_we), .hi_byte(hi_byte),
    .lo_byte(lo_byte), .en_we(en_we), .en_data(en_data), .clr_mask(clr_mask),
    .pre_in(pre_q), .div_in(div_q), .en_in(en_q), .pend_in(irq_pending)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    dit_timer #(.W(CNT_W)) u_tmr (
      .clk(clk), .rst(rst), .we(tmr_we[t]), .hi_byte(hi_byte), .lo_byte(lo_byte),
      .pre_q(pre_q[t]), .div_q(div_q[t]), .expire_q(tick_pulse[t])
    );
  end

  dit_irq_ctrl #(.NSRC(NUM_SRC), .NT(NUM_TMR)) u_irq (
    .clk(clk), .rst(rst), .en_we(en_we), .en_data(en_data), .clr_mask(clr_mask),
    .tick(tick_pulse), .en_q(en_q), .pend_q(irq_pending)
  );
endmodule

// File: tb/dual_interval_timer_test.sv
`timescale 1ns/1ps
module dual_interval_timer_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0, bus_word = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  tick_pulse, irq_pending;
  int checks = 0, errors = 0;

  dual_interval_timer uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_pulse(tick_pulse), .irq_pending(irq_pending)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic w);
    bus_addr = a; bus_wdata = d; bus_word = w; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic w, output logic [15:0] d);
    bus_addr = a; bus_word = w; bus_rd = 1;
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic measure(input int t, output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (!tick_pulse[t] && n < 2000);
  endtask

  task automatic stop_all();
    wr(4'h2, 16'h0000, 1);
    wr(4'h6, 16'h0000, 1);
    wr(4'h8, 16'h0600, 1);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    int seen = 0;
    for (int a = 0; a < 8; a += 2) begin
      rd(a[3:0], 1, d);
      chk("R1 reset reload value", d, 16'hFFFF);
    end
    rd(4'h8, 1, d);
    chk("R1 reset control", d, 16'h0000);
    for (int i = 0; i < 40; i++) begin
      step(1);
      if (tick_pulse != 0 || irq_pending != 0) seen++;
    end
    chk("R1 idle after reset", seen, 0);
  endtask

  task automatic t_word_rw();
    logic [15:0] d;
    stop_all();
    wr(4'h0, 16'h1357, 1); wr(4'h2, 16'h0000, 1);
    wr(4'h4, 16'h2468, 1); wr(4'h6, 16'h0000, 1);
    rd(4'h0, 1, d); chk("R2 t1 prescaler", d, 16'h1357);
    rd(4'h4, 1, d); chk("R2 t2 prescaler", d, 16'h2468);
    wr(4'h2, 16'h0000, 1);
    rd(4'h2, 1, d); chk("R2 t1 divider", d, 16'h0000);
    // R11: rdata holds across a later write
    wr(4'h0, 16'h0000, 1);
    chk("R11 read data held", bus_rdata, 16'h0000);
    rd(4'h4, 1, d);
    wr(4'h4, 16'h9999, 1);
    chk("R11 hold after write", bus_rdata, 16'h2468);
  endtask

  task automatic t_byte();
    logic [15:0] d;
    wr(4'h4, 16'h1234, 1);
    wr(4'h4, 16'h00AB, 0);
    rd(4'h4, 1, d); chk("R3 even byte is high half", d, 16'hAB34);
    wr(4'h5, 16'h00CD, 0);
    rd(4'h4, 1, d); chk("R3 odd byte is low half", d, 16'hABCD);
    rd(4'h4, 0, d); chk("R3 byte read high", d, 16'h00AB);
    rd(4'h5, 0, d); chk("R3 byte read low", d, 16'h00CD);
    wr(4'h6, 16'h0000, 1);
  endtask

  task automatic t_period();
    int n;
    stop_all();
    wr(4'h0, 16'd3, 1); wr(4'h2, 16'd1, 1);
    measure(0, n); chk("R4 first period 8", n, 8);
    step(1); chk("R4 tick one cycle", tick_pulse[0], 1'b0);
    measure(0, n); chk("R4 repeat period 8", n, 7);
    stop_all();
    wr(4'h4, 16'd1, 1); wr(4'h6, 16'd2, 1);
    measure(1, n); chk("R10 P1 D2 period 6", n, 6);
    wr(4'h4, 16'd2, 1); wr(4'h6, 16'd1, 1);
    measure(1, n); chk("R10 P2 D1 period 6", n, 6);
    wr(4'h4, 16'd4, 1); wr(4'h6, 16'd4, 1);
    measure(1, n); chk("R4 period 25", n, 25);
    measure(1, n); chk("R4 repeat period 25", n, 25);
  endtask

  task automatic t_zero();
    int n;
    stop_all();
    wr(4'h8, 16'h0006, 1);
    wr(4'h0, 16'd2, 1);
    measure(0, n); chk("R5 zero divider no tick", n, 2000);
    chk("R5 zero sets no pending", irq_pending, 2'b00);
    wr(4'h0, 16'd0, 1); wr(4'h2, 16'd3, 1);
    measure(0, n); chk("R5 zero prescaler no tick", n, 2000);
    wr(4'h1, 16'h0001, 0);
    measure(0, n); chk("R6 byte write restarts", n, 8);
    wr(4'h8, 16'h0600, 1);
  endtask

  task automatic t_reload();
    int n;
    stop_all();
    wr(4'h0, 16'd3, 1); wr(4'h2, 16'd1, 1);
    step(5);
    wr(4'h0, 16'd3, 1);
    measure(0, n); chk("R6 rewrite restarts count", n, 8);
  endtask

  task automatic t_indep();
    int n;
    stop_all();
    wr(4'h4, 16'd2, 1); wr(4'h6, 16'd3, 1);   // period 12
    step(5);
    wr(4'h0, 16'd1, 1);                       // write to the other timer
    measure(1, n); chk("R7 other timer undisturbed", n, 6);
  endtask

  task automatic t_enable_clear();
    logic [15:0] d;
    int n;
    stop_all();
    wr(4'h0, 16'd3, 1); wr(4'h2, 16'd1, 1);
    measure(0, n); step(2);
    chk("R8 disabled source stays clear", irq_pending, 2'b00);
    wr(4'h8, 16'h0002, 1);
    measure(0, n);
    chk("R8 no pending in tick cycle", irq_pending[0], 1'b0);
    step(1);
    chk("R8 enabled tick sets pending", irq_pending, 2'b01);
    rd(4'h8, 1, d); chk("R12 control readback", d, 16'h0202);
    wr(4'h8, 16'h0000, 0);
    chk("R9 writing zero keeps pending", irq_pending, 2'b01);
    wr(4'h8, 16'h0002, 0);
    chk("R9 byte clear", irq_pending, 2'b00);
    rd(4'h8, 1, d); chk("R9 clear keeps enables", d, 16'h0002);
  endtask

  task automatic t_conflict();
    int n;
    stop_all();
    wr(4'h8, 16'h0002, 1);
    wr(4'h0, 16'd3, 1); wr(4'h2, 16'd1, 1);  // period 8 from this edge
    step(7);
    chk("R4 tick not yet", tick_pulse[0], 1'b0);
    step(1);
    chk("R4 tick at cycle 8", tick_pulse[0], 1'b1);
    wr(4'h8, 16'h0202, 1);                   // clear on the set edge
    chk("R9 clear wins over set", irq_pending[0], 1'b0);
    measure(0, n); step(1);
    chk("R9 later expiry sets again", irq_pending[0], 1'b1);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_word_rw();
    t_byte();
    t_period();
    t_zero();
    t_reload();
    t_indep();
    t_enable_clear();
    t_conflict();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule